// File: doc/BRIEF.md
# Vertical Gate Scan Sequencer

This block drives the row side of a gate-scanned display panel. It counts lines within a frame from a line strobe and a frame strobe, and issues a start token for the vertical shift register. In every line of the scan window it runs a fixed sequence of edges in the horizontal blanking interval. The sequence lowers the gate enable, raises a precharge pulse, toggles the vertical shift clock while the enable is low, and then restores the enable. All delays are parameters counted in reference-clock cycles.

The mode code selects how many active lines the frame has. Every mode other than the full-size one adds a border-blanking pulse over the first lines of the frame, and that pulse is merged into the precharge output. A direction input moves the start token by one line, to match the shift direction of the panel. A polarity flag flips on every line so that the video path can invert its drive.

Top module: `vgs_gate_seq`

## Requirements
- R1: While reset is asserted and after it is released, and before any strobe arrives, `gate_en` is 1 and `vclk`, `vstart`, `pcg_out` and `video_pol` are 0.
- R2: The mode code sets the active line count N: code 0 gives 624, 1 gives 600, 2 gives 572, 3 gives 480, 4 gives 400 and 5 gives 480. Codes 6 and 7 behave as code 0. Over a complete frame, `vclk` toggles exactly N+1 times.
- R3: A `video_end` pulse starts a sequence only if the current line index lies in the window from S to S+N, where S = BLANK_LINES+1. Pulses on other lines are ignored, and so are pulses while a sequence is still running.
- R4: When `video_end` is sampled at edge k, `gate_en` is low from edge k+A up to edge k+D. Here A = EN_FALL_DLY, B = A+PCG_DLY, C = B+VCK_DLY and D = C+EN_RISE_DLY. `vclk` toggles once, at edge k+C.
- R5: The precharge pulse is high from edge k+B for PCG_WIDTH cycles. It lies wholly inside the low phase of the enable, given VCK_DLY+EN_RISE_DLY >= PCG_WIDTH.
- R6: `pcg_out` is the OR of the precharge pulse and the blanking pulse.
- R7: The blanking pulse is high while the line index is below BLANK_LINES in modes 1 to 5. It stays low in modes 0, 6 and 7.
- R8: `vstart` is high for exactly line index S when `scan_down` is 1, and for line index S+1 when it is 0. The blanking pulse therefore ends one or two lines before the start token.
- R9: `video_pol` inverts at every `line_start`.
- R10: The line index is 0 on the line that `frame_start` opens and rises by one per `line_start`. `frame_start` wins when both strobes coincide, and a new `frame_start` restarts the count at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| frame_start | input | 1 | One-cycle strobe opening a frame (line index 0) |
| video_end | input | 1 | One-cycle strobe at the end of the horizontal video period |
| mode | input | 3 | Display-area mode code |
| scan_down | input | 1 | 1 selects downward scan, 0 upward scan |
| vclk | output | 1 | Vertical shift clock, toggles once per scanned line |
| vstart | output | 1 | Vertical start token, one line long |
| gate_en | output | 1 | Gate selection enable, low during the blanking sequence |
| pcg_out | output | 1 | Precharge pulse ORed with border blanking |
| video_pol | output | 1 | Per-line video polarity flag |

## Verification
The hardest case to reach is a `video_end` pulse that lands while an earlier sequence is still in flight, together with pulses on lines just outside the scan window. The stimulus adds a second `video_end` inside the sequence on every seventh line. It also runs every frame several lines past the window, and it cuts one frame short with an early `frame_start`. The bench then confirms, edge by edge and through the per-frame `vclk` toggle count, that none of these pulses produced extra edges.

// File: rtl/vgs_pkg.sv
package vgs_pkg;

  // Active line count for a mode code; unused codes fold onto the full mode.
  function automatic logic [31:0] vgs_active_lines(input logic [2:0] code);
    logic [31:0] n;
    case (code)
      3'd1:    n = 32'd600;
      3'd2:    n = 32'd572;
      3'd3:    n = 32'd480;
      3'd4:    n = 32'd400;
      3'd5:    n = 32'd480;
      default: n = 32'd624;
    endcase
    return n;
  endfunction

  // Full-area modes carry no border blanking.
  function automatic logic vgs_is_full(input logic [2:0] code);
    return (code == 3'd0) || (code == 3'd6) || (code == 3'd7);
  endfunction

endpackage

// File: rtl/vgs_line_track.sv
module vgs_line_track
  import vgs_pkg::*;
#(
  parameter int LINE_W      = 10,
  parameter int BLANK_LINES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_start,
  input  logic       frame_start,
  input  logic [2:0] mode,
  input  logic       scan_down,
  output logic       in_scan,
  output logic       blank,
  output logic       vstart,
  output logic       video_pol
);

  localparam logic [31:0] BL_U       = 32'(BLANK_LINES);
  localparam logic [31:0] START_DOWN = 32'(BLANK_LINES + 1);
  localparam logic [31:0] START_UP   = 32'(BLANK_LINES + 2);

  logic [LINE_W-1:0] idx_q, idx_d;
  logic              idx_en;
  logic              pol_q, pol_d;
  logic              blank_q, blank_d;
  logic              vst_q, vst_d;
  logic [31:0]       idx_now, idx_nxt, last_scan;

  // next-state logic
  always_comb begin
    idx_now   = 32'(idx_q);
    last_scan = START_DOWN + vgs_active_lines(mode);
    in_scan   = (idx_now >= START_DOWN) && (idx_now <= last_scan);

    idx_en = frame_start || (line_start && (idx_q != '1));
    if (frame_start) begin
      idx_d = '0;
    end else begin
      idx_d = idx_q + 1'b1;
    end
    idx_nxt = idx_en ? 32'(idx_d) : idx_now;

    pol_d   = ~pol_q;
    blank_d = !vgs_is_full(mode) && (idx_nxt < BL_U);
    vst_d   = (idx_nxt == (scan_down ? START_DOWN : START_UP));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '1;
      pol_q   <= 1'b0;
      blank_q <= 1'b0;
      vst_q   <= 1'b0;
    end else begin
      if (idx_en) begin
        idx_q <= idx_d;
      end
      if (line_start) begin
        pol_q <= pol_d;
      end
      blank_q <= blank_d;
      vst_q   <= vst_d;
    end
  end

  assign blank     = blank_q;
  assign vstart    = vst_q;
  assign video_pol = pol_q;

endmodule

// File: rtl/vgs_edge_seq.sv
module vgs_edge_seq #(
  parameter int EN_FALL_DLY = 100,
  parameter int PCG_DLY     = 100,
  parameter int PCG_WIDTH   = 120,
  parameter int VCK_DLY     = 100,
  parameter int EN_RISE_DLY = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic video_end,
  input  logic in_scan,
  output logic gate_en,
  output logic precharge,
  output logic vclk
);

  localparam int OFS_FALL    = EN_FALL_DLY;
  localparam int OFS_PCG_ON  = OFS_FALL + PCG_DLY;
  localparam int OFS_PCG_OFF = OFS_PCG_ON + PCG_WIDTH;
  localparam int OFS_VCK     = OFS_PCG_ON + VCK_DLY;
  localparam int OFS_RISE    = OFS_VCK + EN_RISE_DLY;
  localparam int OFS_END     = (OFS_RISE > OFS_PCG_OFF) ? OFS_RISE : OFS_PCG_OFF;
  localparam int TMR_W       = $clog2(OFS_END + 1);

  localparam logic [TMR_W-1:0] T_FALL = TMR_W'(OFS_FALL);
  localparam logic [TMR_W-1:0] T_ON   = TMR_W'(OFS_PCG_ON);
  localparam logic [TMR_W-1:0] T_OFF  = TMR_W'(OFS_PCG_OFF);
  localparam logic [TMR_W-1:0] T_VCK  = TMR_W'(OFS_VCK);
  localparam logic [TMR_W-1:0] T_RISE = TMR_W'(OFS_RISE);
  localparam logic [TMR_W-1:0] T_END  = TMR_W'(OFS_END);

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             busy_q, busy_d;
  logic             gate_q, gate_d;
  logic             pcg_q, pcg_d;
  logic             vck_q, vck_d;
  logic             accept, active, tmr_en;

  // next-state logic
  always_comb begin
    accept = video_end && in_scan && !busy_q;
    active = accept || busy_q;
    tmr_en = active;
    busy_d = busy_q;
    if (accept) begin
      tmr_d  = '0;
      busy_d = 1'b1;
    end else begin
      tmr_d = tmr_q + 1'b1;
      if (busy_q && (tmr_d == T_END)) begin
        busy_d = 1'b0;
      end
    end
    gate_d = !(active && (tmr_d >= T_FALL) && (tmr_d < T_RISE));
    pcg_d  = active && (tmr_d >= T_ON) && (tmr_d < T_OFF);
    vck_d  = vck_q ^ (active && (tmr_d == T_VCK));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      busy_q <= 1'b0;
      gate_q <= 1'b1;
      pcg_q  <= 1'b0;
      vck_q  <= 1'b0;
    end else begin
      if (tmr_en) begin
        tmr_q <= tmr_d;
      end
      busy_q <= busy_d;
      gate_q <= gate_d;
      pcg_q  <= pcg_d;
      vck_q  <= vck_d;
    end
  end

  assign gate_en   = gate_q;
  assign precharge = pcg_q;
  assign vclk      = vck_q;

endmodule

// File: rtl/vgs_gate_seq.sv
module vgs_gate_seq #(
  parameter int LINE_W      = 10,
  parameter int BLANK_LINES = 2,
  parameter int EN_FALL_DLY = 100,
  parameter int PCG_DLY     = 100,
  parameter int PCG_WIDTH   = 120,
  parameter int VCK_DLY     = 100,
  parameter int EN_RISE_DLY = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_start,
  input  logic       frame_start,
  input  logic       video_end,
  input  logic [2:0] mode,
  input  logic       scan_down,
  output logic       vclk,
  output logic       vstart,
  output logic       gate_en,
  output logic       pcg_out,
  output logic       video_pol
);

  logic in_scan;
  logic blank_pulse;
  logic pcg_pulse;

  vgs_line_track #(
    .LINE_W      (LINE_W),
    .BLANK_LINES (BLANK_LINES)
  ) u_line (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_start  (line_start),
    .frame_start (frame_start),
    .mode        (mode),
    .scan_down   (scan_down),
    .in_scan     (in_scan),
    .blank       (blank_pulse),
    .vstart      (vstart),
    .video_pol   (video_pol)
  );

  vgs_edge_seq #(
    .EN_FALL_DLY (EN_FALL_DLY),
    .PCG_DLY     (PCG_DLY),
    .PCG_WIDTH   (PCG_WIDTH),
    .VCK_DLY     (VCK_DLY),
    .EN_RISE_DLY (EN_RISE_DLY)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .video_end (video_end),
    .in_scan   (in_scan),
    .gate_en   (gate_en),
    .precharge (pcg_pulse),
    .vclk      (vclk)
  );

  assign pcg_out = pcg_pulse | blank_pulse;

endmodule

// File: rtl/vgs_gate_seq_chk.sv
module vgs_gate_seq_chk
  import vgs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       line_start,
  input logic [2:0] mode,
  input logic       vclk,
  input logic       gate_en,
  input logic       video_pol,
  input logic       vstart,
  input logic       precharge,
  input logic       blank
);

  // R4: the shift clock only moves while the gate enable is held low
  a_r4_vclk_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vclk) |-> !gate_en);

  // R5: the precharge pulse never overlaps an enabled gate
  a_r5_pcg_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    precharge |-> !gate_en);

  // R9: polarity inverts after each line strobe
  a_r9_pol_flip: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (video_pol != $past(video_pol)));

  // R7: full-area modes keep the border blanking dark
  a_r7_full_no_blank: assert property (@(posedge clk) disable iff (!rst_n)
    vgs_is_full(mode) |=> !blank);

  // R8: the start token never shares a line with blanking
  a_r8_start_after_blank: assert property (@(posedge clk) disable iff (!rst_n)
    vstart |-> !blank);

endmodule

bind vgs_gate_seq vgs_gate_seq_chk i_vgs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_start (line_start),
  .mode       (mode),
  .vclk       (vclk),
  .gate_en    (gate_en),
  .video_pol  (video_pol),
  .vstart     (vstart),
  .precharge  (pcg_pulse),
  .blank      (blank_pulse)
);

// File: tb/test_vgs_gate_seq.sv
module test_vgs_gate_seq;

  localparam int CLK_PERIOD = 10;
  localparam int P_BL       = 2;
  localparam int P_FALL     = 3;
  localparam int P_PCG_DLY  = 3;
  localparam int P_PCG_W    = 5;
  localparam int P_VCK_DLY  = 4;
  localparam int P_RISE_DLY = 2;
  localparam int LINE_CYC   = 20;
  localparam int VE_OFS     = 6;
  localparam int S_LINE     = P_BL + 1;
  localparam int IDX_MAX    = 1023;
  localparam int WATCHDOG   = 150000;

  // absolute offsets from the accepting edge, per R4/R5
  localparam int T_FALL = P_FALL;
  localparam int T_ON   = P_FALL + P_PCG_DLY;
  localparam int T_OFF  = T_ON + P_PCG_W;
  localparam int T_VCK  = T_ON + P_VCK_DLY;
  localparam int T_RISE = T_VCK + P_RISE_DLY;
  localparam int T_END  = (T_RISE > T_OFF) ? T_RISE : T_OFF;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_start, frame_start, video_end, scan_down;
  logic [2:0] mode;
  logic       vclk, vstart, gate_en, pcg_out, video_pol;

  int nchecks = 0;
  int nerrors = 0;
  int cur_line = 0;
  int toggles = 0;
  int cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vgs_gate_seq #(
    .BLANK_LINES (P_BL),
    .EN_FALL_DLY (P_FALL),
    .PCG_DLY     (P_PCG_DLY),
    .PCG_WIDTH   (P_PCG_W),
    .VCK_DLY     (P_VCK_DLY),
    .EN_RISE_DLY (P_RISE_DLY)
  ) i_vgs_gate_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_start  (line_start),
    .frame_start (frame_start),
    .video_end   (video_end),
    .mode        (mode),
    .scan_down   (scan_down),
    .vclk        (vclk),
    .vstart      (vstart),
    .gate_en     (gate_en),
    .pcg_out     (pcg_out),
    .video_pol   (video_pol)
  );

  function automatic int lines_of(input logic [2:0] m);
    case (m)
      3'd1: return 600;
      3'd2: return 572;
      3'd3: return 480;
      3'd4: return 400;
      3'd5: return 480;
      default: return 624;
    endcase
  endfunction

  function automatic bit is_full(input logic [2:0] m);
    return (m == 3'd0) || (m >= 3'd6);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nerrors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  m_idx;
  bit  m_pol, m_blank, m_vst, m_busy, m_vclk, m_gate, m_pcg;
  longint m_cnt, m_st;

  always @(posedge clk or negedge rst_n) begin
    int  n;
    int  j;
    bit  acc;
    if (!rst_n) begin
      m_idx = IDX_MAX; m_pol = 0; m_blank = 0; m_vst = 0;
      m_busy = 0; m_vclk = 0; m_gate = 1; m_pcg = 0; m_cnt = 0; m_st = 0;
    end else begin
      m_cnt++;
      n   = lines_of(mode);
      acc = video_end && !m_busy && (m_idx >= S_LINE) && (m_idx <= S_LINE + n);
      if (acc) begin
        m_busy = 1;
        m_st   = m_cnt;
      end
      if (m_busy) begin
        j      = int'(m_cnt - m_st);
        m_gate = !((j >= T_FALL) && (j < T_RISE));
        m_pcg  = (j >= T_ON) && (j < T_OFF);
        if (j == T_VCK) m_vclk = !m_vclk;
        if (j == T_END) m_busy = 0;
      end
      if (frame_start) m_idx = 0;
      else if (line_start && m_idx < IDX_MAX) m_idx++;
      if (line_start) m_pol = !m_pol;
      m_blank = !is_full(mode) && (m_idx < P_BL);
      m_vst   = (m_idx == (scan_down ? S_LINE : S_LINE + 1));
    end
  end

  // per-cycle comparison and monitors, away from the active edge
  bit prev_vclk = 0, prev_vst = 0, prev_pcg = 0;
  int pcg_run = 0;

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      nchecks++;
      if (gate_en !== m_gate) begin
        nerrors++; $display("FAIL R4 gate_en: actual %0b expected %0b at %0t", gate_en, m_gate, $time);
      end
      if (vclk !== m_vclk) begin
        nerrors++; $display("FAIL R4 vclk: actual %0b expected %0b at %0t", vclk, m_vclk, $time);
      end
      if (pcg_out !== (m_pcg | m_blank)) begin
        nerrors++; $display("FAIL R6 pcg_out: actual %0b expected %0b at %0t", pcg_out, m_pcg | m_blank, $time);
      end
      if (vstart !== m_vst) begin
        nerrors++; $display("FAIL R8 vstart: actual %0b expected %0b at %0t", vstart, m_vst, $time);
      end
      if (video_pol !== m_pol) begin
        nerrors++; $display("FAIL R9 video_pol: actual %0b expected %0b at %0t", video_pol, m_pol, $time);
      end
      if (vclk != prev_vclk) toggles++;
      if (vstart && !prev_vst) check("R8 start line", cur_line, scan_down ? S_LINE : S_LINE + 1);
      if (is_full(mode)) begin
        if (pcg_out) pcg_run++;
        else if (prev_pcg) begin
          check("R5 precharge width", pcg_run, P_PCG_W);
          pcg_run = 0;
        end
      end else begin
        pcg_run = 0;
      end
      prev_vclk = vclk;
      prev_vst  = vstart;
      prev_pcg  = pcg_out;
    end
  end

  task automatic run_line(input int l, input bit fs, input bit extra);
    for (int c = 0; c < LINE_CYC; c++) begin
      @(negedge clk);
      if (c == 1 && fs) check("R7 blanking at frame open", int'(pcg_out), int'(!is_full(mode)));
      if (c == 0) cur_line = l;
      line_start  = (c == 0);
      frame_start = (c == 0) && fs;
      video_end   = (c == VE_OFS) || (extra && (c == VE_OFS + 3));
    end
  endtask

  task automatic run_frame(input logic [2:0] m, input bit down, input int nlines,
                           input bit extras, input string req);
    @(negedge clk);
    mode = m;
    scan_down = down;
    toggles = 0;
    for (int l = 0; l < nlines; l++) begin
      run_line(l, l == 0, extras && (l % 7 == 3));
    end
    @(negedge clk);
    if (nlines >= lines_of(m) + S_LINE + 1) check(req, toggles, lines_of(m) + 1);
    else check(req, toggles, nlines - S_LINE);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      nchecks++;
      nerrors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    line_start = 0; frame_start = 0; video_end = 0;
    mode = 3'd0; scan_down = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 gate_en", int'(gate_en), 1);
    check("R1 vclk", int'(vclk), 0);
    check("R1 vstart", int'(vstart), 0);
    check("R1 pcg_out", int'(pcg_out), 0);
    check("R1 video_pol", int'(video_pol), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R3: video_end before any frame is outside the window
    video_end = 1'b1;
    @(negedge clk);
    video_end = 1'b0;
    repeat (T_END + 2) @(negedge clk);
    check("R1 idle gate_en", int'(gate_en), 1);
    check("R3 no edge before frame", int'(vclk), 0);

    run_frame(3'd0, 1'b1, lines_of(3'd0) + 8, 1'b0, "R2 mode 0 toggles");
    run_frame(3'd1, 1'b0, lines_of(3'd1) + 8, 1'b1, "R3 mode 1 busy pulses ignored");
    run_frame(3'd2, 1'b1, lines_of(3'd2) + 8, 1'b1, "R3 mode 2 busy pulses ignored");
    run_frame(3'd3, 1'b0, 50, 1'b0, "R10 frame cut short");
    run_frame(3'd3, 1'b0, lines_of(3'd3) + 8, 1'b0, "R2 mode 3 toggles");
    run_frame(3'd4, 1'b1, lines_of(3'd4) + 8, 1'b0, "R2 mode 4 toggles");
    run_frame(3'd5, 1'b0, lines_of(3'd5) + 8, 1'b0, "R2 mode 5 toggles");
    run_frame(3'd7, 1'b1, lines_of(3'd7) + 8, 1'b0, "R2 mode 7 toggles");

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
      $finish;
    end
  end

endmodule